// File: doc/BRIEF.md
# Host Mailbox Register File with Streaming Buffer

This block is the register face of a message mailbox. A host talks to it through a small little-endian register port that takes 1, 2, 4 or 8 byte accesses. Through that port the host programs a buffer length and a 64-bit transfer address, issues commands, and reads back a 16-bit result code. Message bytes are moved through a single data window. Each access to the window reads or writes as many bytes as the access is wide, starting at an internal offset, and then moves the offset forward by that many bytes. The bytes live in a parameterised on-block byte RAM.

The block runs two commands itself: one clears the buffer programming and one rewinds the window offset. The two message commands are passed to an external service engine over a start/done handshake, and the result code that engine returns becomes the block's status. A checksum register gives the host a CRC32C over every byte streamed so far. The block computes it one byte per clock and holds off further requests until the value is ready. A flags word reports whether the platform uses streamed (non-DMA) transfers, as set by a strap input.

Top module: `mbox_regfile`

## Requirements
- R1: A read at offset 0x00 returns the MAGIC parameter, zero-extended. A read at any offset other than 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18 or 0x1C returns all ones on the 64-bit read bus.
- R2: Writing offset 0x04 executes the command in wdata[31:0]. The resulting 16-bit code is latched, and later reads of 0x04 return it. A command value other than 0, 1, 2 or 3 gives code 2 (not supported). Code 0 means success and code 1 means bad buffer size.
- R3: Command 0 sets the buffer length (0x08) and both address words (0x0C low, 0x10 high) to zero and gives code 0.
- R4: A write to 0x08 stores the 64-bit write value clamped to BUF_BYTES.
- R5: Command 3 sets the window offset to zero and gives code 0.
- R6: req_size encodes the width as 1 << req_size bytes (0=1, 1=2, 2=4, 3=8). An access at offset 0x14 moves that many bytes starting at the window offset, packed little-endian with the lowest address in bits 7:0, and then adds the width to the offset.
- R7: When offset + width exceeds the buffer length, a window read returns zero, a window write changes no byte, and the offset stays where it was.
- R8: A read at 0x18 returns, zero-extended, the CRC32C of buffer bytes 0 to offset-1. The CRC is reflected with polynomial 0x82F63B78, seeded with 0xFFFFFFFF, and has no final inversion, so an offset of 0 gives 0xFFFFFFFF. req_ready stays low until the response arrives, and writes to 0x18 have no effect.
- R9: A read at 0x1C returns the stream_mode input in bit 0 and zeros elsewhere. Writes to 0x1C have no effect.
- R10: Commands 1 and 2 raise eng_start for exactly one cycle, with eng_cmd equal to the command. req_ready then stays low until eng_done is seen, and the eng_status value sampled with eng_done becomes the latched code.
- R11: An accepted read of any offset except 0x18 gives rsp_valid in the following cycle. The two address words read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_size | input | 2 | Access width code, bytes = 1 << req_size |
| req_wdata | input | 64 | Write data, little-endian |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| rsp_valid | output | 1 | Read data valid for one cycle |
| rsp_rdata | output | 64 | Read data |
| stream_mode | input | 1 | Strap reported in the flags word |
| eng_start | output | 1 | One-cycle start pulse to the service engine |
| eng_cmd | output | 8 | Command handed to the engine |
| eng_done | input | 1 | Engine finished |
| eng_status | input | 16 | Engine result code, sampled with eng_done |

## Verification
The assertions rely on three things from the environment. A requester keeps its request fields steady until the request is accepted. eng_done arrives only while a delegated command is pending, and never in the same cycle as eng_start. req_size always carries one of its four codes. The bench keeps to these rules. It drives requests on the falling edge and waits for req_ready before releasing them. Its engine model raises eng_done only a few cycles after it sees a start pulse. The data-window sweep covers every width at every start offset of a 12-byte buffer inside a 16-byte RAM, so overrun cases are exercised without ever addressing past the RAM.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_CRC,
      ST_ENG
   } mbox_state_e;

   localparam logic [15:0] STS_OK       = 16'd0;
   localparam logic [15:0] STS_BAD_SIZE = 16'd1;
   localparam logic [15:0] STS_NO_SUPP  = 16'd2;

   localparam logic [31:0] CMD_CLEAR       = 32'd0;
   localparam logic [31:0] CMD_XFER_DMA    = 32'd1;
   localparam logic [31:0] CMD_XFER_STREAM = 32'd2;
   localparam logic [31:0] CMD_REWIND      = 32'd3;

   localparam logic [7:0] OFS_IDENT = 8'h00;
   localparam logic [7:0] OFS_CMD   = 8'h04;
   localparam logic [7:0] OFS_LEN   = 8'h08;
   localparam logic [7:0] OFS_ALO   = 8'h0C;
   localparam logic [7:0] OFS_AHI   = 8'h10;
   localparam logic [7:0] OFS_WIN   = 8'h14;
   localparam logic [7:0] OFS_CRC   = 8'h18;
   localparam logic [7:0] OFS_FLAGS = 8'h1C;

   localparam logic [31:0] CRC_POLY = 32'h82F6_3B78;
   localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

endpackage

// File: rtl/mbox_window.sv
// Window bound check and lane selection for one data-window access.
module mbox_window #(
   parameter int unsigned OFF_W = 5
) (
   input  logic [OFF_W-1:0] off,
   input  logic [31:0]      buf_len,
   input  logic [1:0]       acc_size,
   output logic             fits,
   output logic [7:0]       lane_en,
   output logic [OFF_W-1:0] off_next
);
   logic [3:0]  nbytes;
   logic [32:0] end_pos;

   assign nbytes  = 4'd1 << acc_size;
   assign end_pos = 33'(off) + 33'(nbytes);
   assign fits    = end_pos <= {1'b0, buf_len};

   for (genvar g = 0; g < 8; g++) begin : g_lane
      assign lane_en[g] = 4'(g) < nbytes;
   end

   assign off_next = fits ? end_pos[OFF_W-1:0] : off;
endmodule

// File: rtl/mbox_byte_ram.sv
// Byte RAM: eight-lane write and read at a base index, plus one checksum read port.
module mbox_byte_ram #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned OFF_W = 5
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [OFF_W-1:0] base,
   input  logic [7:0]       lane_en,
   input  logic [63:0]      wdata,
   output logic [63:0]      rd_lanes,
   input  logic [OFF_W-1:0] crc_idx,
   output logic [7:0]       crc_byte
);
   localparam int unsigned IDX_W = $clog2(DEPTH);

   logic [7:0]       mem [DEPTH];
   logic [IDX_W-1:0] pos_idx [8];
   logic [7:0]       in_rng;

   for (genvar g = 0; g < 8; g++) begin : g_lane
      logic [OFF_W:0] pos;
      assign pos        = (OFF_W+1)'(base) + (OFF_W+1)'(g);
      assign in_rng[g]  = pos < (OFF_W+1)'(DEPTH);
      assign pos_idx[g] = pos[IDX_W-1:0];
      assign rd_lanes[8*g +: 8] = in_rng[g] ? mem[pos_idx[g]] : 8'h00;
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         for (int k = 0; k < 8; k++) begin
            if (lane_en[k] && in_rng[k]) mem[pos_idx[k]] <= wdata[8*k +: 8];
         end
      end
   end

   assign crc_byte = (crc_idx < OFF_W'(DEPTH)) ? mem[crc_idx[IDX_W-1:0]] : 8'h00;
endmodule

// File: rtl/mbox_crc_seq.sv
// Serial CRC32C, one buffer byte per clock from index 0 up to a count.
module mbox_crc_seq
   import mbox_pkg::*;
#(
   parameter int unsigned OFF_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [OFF_W-1:0] count,
   output logic [OFF_W-1:0] rd_idx,
   input  logic [7:0]       rd_byte,
   output logic             done,
   output logic [31:0]      result
);
   logic             busy;
   logic [OFF_W-1:0] limit;
   logic [31:0]      crc_nxt;

   always_comb begin
      crc_nxt = result ^ {24'h0, rd_byte};
      for (int b = 0; b < 8; b++) begin
         crc_nxt = crc_nxt[0] ? ((crc_nxt >> 1) ^ CRC_POLY) : (crc_nxt >> 1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         done   <= 1'b0;
         rd_idx <= '0;
         limit  <= '0;
         result <= CRC_SEED;
      end else begin
         done <= 1'b0;
         if (start) begin
            busy   <= 1'b1;
            rd_idx <= '0;
            limit  <= count;
            result <= CRC_SEED;
         end else if (busy) begin
            if (rd_idx == limit) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               result <= crc_nxt;
               rd_idx <= rd_idx + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/mbox_regfile.sv
module mbox_regfile
   import mbox_pkg::*;
#(
   parameter int unsigned BUF_BYTES = 16,
   parameter int unsigned ADDR_W    = 6,
   parameter logic [31:0] MAGIC     = 32'h4D42_5852
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic [63:0]       req_wdata,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic [63:0]       rsp_rdata,
   input  logic              stream_mode,
   output logic              eng_start,
   output logic [7:0]        eng_cmd,
   input  logic              eng_done,
   input  logic [15:0]       eng_status
);
   localparam int unsigned OFF_W = $clog2(BUF_BYTES + 1);

   if (BUF_BYTES < 8 || BUF_BYTES > 4096) begin : g_bad_depth
      $error("mbox_regfile: BUF_BYTES must lie in 8..4096");
   end
   if (ADDR_W < 6 || ADDR_W > 8) begin : g_bad_addr
      $error("mbox_regfile: ADDR_W must lie in 6..8");
   end

   mbox_state_e      state;
   logic [15:0]      status_q;
   logic [31:0]      size_q;
   logic [31:0]      alo_q;
   logic [31:0]      ahi_q;
   logic [OFF_W-1:0] off_q;

   logic [7:0]       addr8;
   logic             acc;
   logic             fits;
   logic [7:0]       lane_en;
   logic [OFF_W-1:0] off_next;
   logic [63:0]      rd_lanes;
   logic [63:0]      lane_mask;
   logic [63:0]      rd_val;
   logic [OFF_W-1:0] crc_idx;
   logic [7:0]       crc_byte;
   logic             crc_done;
   logic [31:0]      crc_res;
   logic             win_acc;

   assign addr8     = 8'(req_addr);
   assign req_ready = (state == ST_IDLE);
   assign acc       = req_valid && req_ready;
   assign win_acc   = acc && (addr8 == OFS_WIN);

   mbox_window #(.OFF_W(OFF_W)) u_win (
      .off      (off_q),
      .buf_len  (size_q),
      .acc_size (req_size),
      .fits     (fits),
      .lane_en  (lane_en),
      .off_next (off_next)
   );

   mbox_byte_ram #(.DEPTH(BUF_BYTES), .OFF_W(OFF_W)) u_ram (
      .clk      (clk),
      .wr_en    (win_acc && req_write && fits),
      .base     (off_q),
      .lane_en  (lane_en),
      .wdata    (req_wdata),
      .rd_lanes (rd_lanes),
      .crc_idx  (crc_idx),
      .crc_byte (crc_byte)
   );

   mbox_crc_seq #(.OFF_W(OFF_W)) u_crc (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (acc && !req_write && (addr8 == OFS_CRC)),
      .count   (off_q),
      .rd_idx  (crc_idx),
      .rd_byte (crc_byte),
      .done    (crc_done),
      .result  (crc_res)
   );

   for (genvar g = 0; g < 8; g++) begin : g_mask
      assign lane_mask[8*g +: 8] = {8{lane_en[g]}};
   end

   always_comb begin
      case (addr8)
         OFS_IDENT: rd_val = 64'(MAGIC);
         OFS_CMD:   rd_val = 64'(status_q);
         OFS_LEN:   rd_val = 64'(size_q);
         OFS_ALO:   rd_val = 64'(alo_q);
         OFS_AHI:   rd_val = 64'(ahi_q);
         OFS_WIN:   rd_val = fits ? (rd_lanes & lane_mask) : 64'h0;
         OFS_FLAGS: rd_val = 64'(stream_mode);
         default:   rd_val = '1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         status_q  <= STS_OK;
         size_q    <= '0;
         alo_q     <= '0;
         ahi_q     <= '0;
         off_q     <= '0;
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
         eng_start <= 1'b0;
         eng_cmd   <= '0;
      end else begin
         rsp_valid <= 1'b0;
         eng_start <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (acc && req_write) begin
                  case (addr8)
                     OFS_CMD: begin
                        case (req_wdata[31:0])
                           CMD_CLEAR: begin
                              size_q   <= '0;
                              alo_q    <= '0;
                              ahi_q    <= '0;
                              status_q <= STS_OK;
                           end
                           CMD_REWIND: begin
                              off_q    <= '0;
                              status_q <= STS_OK;
                           end
                           CMD_XFER_DMA, CMD_XFER_STREAM: begin
                              eng_start <= 1'b1;
                              eng_cmd   <= req_wdata[7:0];
                              state     <= ST_ENG;
                           end
                           default: status_q <= STS_NO_SUPP;
                        endcase
                     end
                     OFS_LEN: size_q <= (req_wdata > 64'(BUF_BYTES)) ?
                                        32'(BUF_BYTES) : req_wdata[31:0];
                     OFS_ALO: alo_q <= req_wdata[31:0];
                     OFS_AHI: ahi_q <= req_wdata[31:0];
                     OFS_WIN: off_q <= off_next;
                     default: ;
                  endcase
               end else if (acc) begin
                  if (addr8 == OFS_CRC) begin
                     state <= ST_CRC;
                  end else begin
                     rsp_valid <= 1'b1;
                     rsp_rdata <= rd_val;
                     if (addr8 == OFS_WIN) off_q <= off_next;
                  end
               end
            end
            ST_CRC: begin
               if (crc_done) begin
                  rsp_valid <= 1'b1;
                  rsp_rdata <= 64'(crc_res);
                  state     <= ST_IDLE;
               end
            end
            ST_ENG: begin
               if (eng_done) begin
                  status_q <= eng_status;
                  state    <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mbox_regfile_chk.sv
module mbox_regfile_chk #(
   parameter int unsigned BUF_BYTES = 16,
   parameter int unsigned ADDR_W    = 6,
   parameter int unsigned OFF_W     = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic [1:0]        req_size,
   input logic              rsp_valid,
   input logic [63:0]       rsp_rdata,
   input logic              eng_start,
   input logic [OFF_W-1:0]  off_q,
   input logic [31:0]       size_q,
   input logic              in_crc
);
   logic       acc;
   logic [7:0] a8;
   logic [3:0] nb;
   logic       unmapped;
   logic       over;
   int unsigned crc_wait;

   assign acc      = req_valid && req_ready;
   assign a8       = 8'(req_addr);
   assign nb       = 4'd1 << req_size;
   assign unmapped = (a8 > 8'h1C) || (a8[1:0] != 2'b00);
   assign over     = (33'(off_q) + 33'(nb)) > {1'b0, size_q};

   always_ff @(posedge clk) begin
      if (!rst_n) crc_wait <= 0;
      else if (in_crc) crc_wait <= crc_wait + 1;
      else crc_wait <= 0;
   end

   p_len_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
      size_q <= 32'(BUF_BYTES));

   p_off_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      32'(off_q) <= 32'(BUF_BYTES));

   p_off_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && a8 == 8'h14) |=> (off_q == $past(off_q)) ||
         (32'(off_q) == 32'($past(off_q)) + (32'd1 << $past(req_size))));

   p_overrun_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && a8 == 8'h14 && over) |=> (off_q == $past(off_q)));

   p_read_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !req_write && a8 != 8'h18) |=> rsp_valid);

   p_unmapped_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !req_write && unmapped) |=> (rsp_rdata == '1));

   p_start_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start);

   p_start_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> !req_ready);

   p_crc_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
      crc_wait <= BUF_BYTES + 3);
endmodule

bind mbox_regfile mbox_regfile_chk #(
   .BUF_BYTES (BUF_BYTES),
   .ADDR_W    (ADDR_W),
   .OFF_W     (OFF_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_write (req_write),
   .req_addr  (req_addr),
   .req_size  (req_size),
   .rsp_valid (rsp_valid),
   .rsp_rdata (rsp_rdata),
   .eng_start (eng_start),
   .off_q     (off_q),
   .size_q    (size_q),
   .in_crc    (state == mbox_pkg::ST_CRC)
);

// File: tb/mbox_regfile_bench.sv
module mbox_regfile_bench;
   localparam int unsigned BUF_BYTES = 16;
   localparam logic [31:0] MAGIC = 32'h4D42_5852;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [5:0]  req_addr = '0;
   logic [1:0]  req_size = '0;
   logic [63:0] req_wdata = '0;
   logic        req_ready;
   logic        rsp_valid;
   logic [63:0] rsp_rdata;
   logic        stream_mode = 1'b1;
   logic        eng_start;
   logic [7:0]  eng_cmd;
   logic        eng_done = 1'b0;
   logic [15:0] eng_status = '0;

   int tests = 0;
   int fails = 0;
   int n_start = 0;
   logic [7:0] last_cmd = '0;
   logic [7:0] ref_mem [BUF_BYTES];

   always #5 clk = ~clk;

   mbox_regfile #(.BUF_BYTES(BUF_BYTES), .ADDR_W(6), .MAGIC(MAGIC)) u_mbox_regfile (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
      .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .stream_mode(stream_mode), .eng_start(eng_start), .eng_cmd(eng_cmd),
      .eng_done(eng_done), .eng_status(eng_status)
   );

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic bus_wr(input logic [5:0] a, input logic [1:0] sz, input logic [63:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = sz; req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      while (!req_ready) @(negedge clk);
   endtask

   task automatic bus_rd(input logic [5:0] a, input logic [1:0] sz, output logic [63:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      while (!rsp_valid) @(negedge clk);
      d = rsp_rdata;
   endtask

   function automatic logic [31:0] ref_crc(input int n);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int i = 0; i < n; i++) begin
         c = c ^ 32'(ref_mem[i]);
         for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'h82F6_3B78) : (c >> 1);
      end
      return c;
   endfunction

   // engine model
   initial begin
      forever begin
         @(negedge clk);
         if (eng_start) begin
            n_start++;
            last_cmd = eng_cmd;
            repeat (3) @(negedge clk);
            eng_status = (last_cmd == 8'd1) ? 16'hA001 : 16'h0001;
            eng_done = 1'b1;
            @(negedge clk);
            eng_done = 1'b0;
         end
      end
   end

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
   end

   initial begin
      logic [63:0] d;
      logic [63:0] e;
      int len;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      bus_rd(6'h04, 2'd2, d); check("R2 reset status", d, 64'h0);
      bus_rd(6'h08, 2'd2, d); check("R4 reset length", d, 64'h0);
      bus_rd(6'h0C, 2'd2, d); check("R11 reset addr lo", d, 64'h0);

      // R1
      bus_rd(6'h00, 2'd2, d); check("R1 magic", d, 64'(MAGIC));
      bus_rd(6'h20, 2'd2, d); check("R1 unmapped 0x20", d, '1);
      bus_rd(6'h03, 2'd0, d); check("R1 unmapped 0x03", d, '1);
      bus_rd(6'h3C, 2'd1, d); check("R1 unmapped 0x3C", d, '1);

      // R11 address words
      bus_wr(6'h0C, 2'd2, 64'hDEAD_BEEF);
      bus_wr(6'h10, 2'd2, 64'h1234_5678);
      bus_rd(6'h0C, 2'd2, d); check("R11 addr lo", d, 64'hDEAD_BEEF);
      bus_rd(6'h10, 2'd2, d); check("R11 addr hi", d, 64'h1234_5678);

      // R4 clamp
      bus_wr(6'h08, 2'd2, 64'd100);
      bus_rd(6'h08, 2'd2, d); check("R4 clamp 100", d, 64'(BUF_BYTES));
      bus_wr(6'h08, 2'd3, 64'h1_0000_0004);
      bus_rd(6'h08, 2'd2, d); check("R4 clamp wide", d, 64'(BUF_BYTES));
      bus_wr(6'h08, 2'd2, 64'd10);
      bus_rd(6'h08, 2'd2, d); check("R4 keep 10", d, 64'd10);

      // R9 flags
      bus_rd(6'h1C, 2'd2, d); check("R9 flags set", d, 64'h1);
      bus_wr(6'h1C, 2'd2, 64'h0);
      bus_rd(6'h1C, 2'd2, d); check("R9 flags write ignored", d, 64'h1);
      stream_mode = 1'b0;
      bus_rd(6'h1C, 2'd2, d); check("R9 flags clear", d, 64'h0);

      // fill the buffer one byte at a time
      bus_wr(6'h08, 2'd2, 64'(BUF_BYTES));
      bus_wr(6'h04, 2'd2, 64'd3);
      for (int i = 0; i < BUF_BYTES; i++) begin
         ref_mem[i] = 8'((i * 37 + 11) & 8'hFF);
         bus_wr(6'h14, 2'd0, 64'(ref_mem[i]));
      end
      bus_rd(6'h18, 2'd2, d); check("R8 crc full buffer", d, 64'(ref_crc(BUF_BYTES)));

      // R6 R7 R8 sweep over width and start offset in a 12-byte buffer
      len = 12;
      bus_wr(6'h08, 2'd2, 64'(len));
      for (int w = 0; w < 4; w++) begin
         for (int s = 0; s <= len; s++) begin
            int nb;
            int end_off;
            nb = 1 << w;
            bus_wr(6'h04, 2'd2, 64'd3);
            for (int k = 0; k < s; k++) bus_rd(6'h14, 2'd0, d);
            bus_rd(6'h14, 2'(w), d);
            e = '0;
            if (s + nb <= len) begin
               for (int i = 0; i < nb; i++) e = e | (64'(ref_mem[s + i]) << (8 * i));
               end_off = s + nb;
            end else begin
               end_off = s;
            end
            check("R6 R7 window read", d, e);
            bus_rd(6'h18, 2'd2, d);
            check("R8 R6 crc after read", d, 64'(ref_crc(end_off)));
         end
      end

      // R7 write discard
      bus_wr(6'h04, 2'd2, 64'd3);
      bus_wr(6'h14, 2'd3, 64'h0807_0605_0403_0201);
      bus_wr(6'h14, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
      bus_wr(6'h14, 2'd2, 64'h3333_3333);
      bus_wr(6'h14, 2'd2, 64'h4444_4444);
      for (int i = 0; i < 8; i++) ref_mem[i] = 8'(i + 1);
      for (int i = 8; i < 12; i++) ref_mem[i] = 8'h33;
      bus_rd(6'h18, 2'd2, d); check("R7 offset after rejected writes", d, 64'(ref_crc(12)));
      bus_wr(6'h08, 2'd2, 64'(BUF_BYTES));
      bus_wr(6'h04, 2'd2, 64'd3);
      bus_rd(6'h14, 2'd3, d); check("R6 readback 8", d, 64'h0807_0605_0403_0201);
      bus_rd(6'h14, 2'd2, d); check("R7 readback 4", d, 64'h3333_3333);
      e = '0;
      for (int i = 0; i < 4; i++) e = e | (64'(ref_mem[12 + i]) << (8 * i));
      bus_rd(6'h14, 2'd2, d); check("R7 tail untouched", d, e);

      // R8 write ignored, R5 rewind
      bus_wr(6'h18, 2'd2, 64'h0);
      bus_rd(6'h18, 2'd2, d); check("R8 crc after ignored write", d, 64'(ref_crc(16)));
      bus_wr(6'h04, 2'd2, 64'd3);
      bus_rd(6'h04, 2'd2, d); check("R5 rewind status", d, 64'h0);
      bus_rd(6'h18, 2'd2, d); check("R5 R8 crc at offset 0", d, 64'hFFFF_FFFF);

      // R2 unknown commands
      bus_wr(6'h04, 2'd2, 64'd7);
      bus_rd(6'h04, 2'd2, d); check("R2 unknown 7", d, 64'h2);
      bus_wr(6'h04, 2'd2, 64'h0000_0100);
      bus_rd(6'h04, 2'd2, d); check("R2 unknown 0x100", d, 64'h2);

      // R10 engine commands
      bus_wr(6'h04, 2'd2, 64'd1);
      bus_rd(6'h04, 2'd2, d); check("R10 engine status cmd1", d, 64'hA001);
      check("R10 engine cmd1 code", 64'(last_cmd), 64'd1);
      bus_wr(6'h04, 2'd2, 64'd2);
      bus_rd(6'h04, 2'd2, d); check("R10 engine status cmd2", d, 64'h0001);
      check("R10 engine cmd2 code", 64'(last_cmd), 64'd2);
      check("R10 start count", 64'(n_start), 64'd2);

      // R3 clear command
      bus_wr(6'h0C, 2'd2, 64'h55);
      bus_wr(6'h10, 2'd2, 64'h66);
      bus_wr(6'h04, 2'd2, 64'd0);
      bus_rd(6'h04, 2'd2, d); check("R3 clear status", d, 64'h0);
      bus_rd(6'h08, 2'd2, d); check("R3 clear length", d, 64'h0);
      bus_rd(6'h0C, 2'd2, d); check("R3 clear addr lo", d, 64'h0);
      bus_rd(6'h10, 2'd2, d); check("R3 clear addr hi", d, 64'h0);
      bus_rd(6'h14, 2'd0, d); check("R7 read with zero length", d, 64'h0);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule